// File: doc/BRIEF.md
# Multi-Link Event Builder

This block sits between sixteen front-end readout links and one or two serial output lines. Each front-end pushes its hit words for every accepted crossing on its own, without being polled, and closes each crossing with an end-of-event marker. The builder holds the words in one receive queue per link and keeps a short queue of pending triggers. For each pending trigger it sends one event: a header with the trigger ID and the number of merged crossings, then the hits grouped by link in ascending link order, then a trailer and a word of per-link overflow flags.

A trigger that spans several contiguous crossings is built as a single event. The builder takes that many end-of-event markers from each link, so all the hits for the span end up in one group per link. A link that never sends its marker is given up on after a fixed idle time. Output words are framed and shifted out at one of three bit rates. A second line can be enabled that carries every other bit.

Top module: `evb_top`

## Requirements
- R1: While reset is asserted, both serial lines are 0 and `trig_ready` is 1.
- R2: Each 16-bit output word goes out as an 18-bit frame: a start bit of 1, the 16 data bits most significant first, and a stop bit of 0. With `dual_en` low, frames use `dout0` only, `dout1` stays 0, and both lines are 0 between frames.
- R3: With `dual_en` high, frame bit 2k goes on `dout0` and frame bit 2k+1 goes on `dout1` during bit period k, so a frame takes 9 bit periods.
- R4: A bit period lasts 4, 2 or 1 clock cycles for `rate_sel` values 0, 1 and 2 (3 behaves like 2). Both lines change only at bit-period boundaries.
- R5: An event starts with the header word {4'hE, trigger length[3:0], trigger ID[7:0]}. It ends with the trailer word 16'hF000 followed by the overflow mask word, whose bit i belongs to link i.
- R6: Links are visited from 0 to 15. A link that has hits for the event produces the word {4'hD, 8'h00, link[3:0]} followed by its hits, each sent as {4'h0, hit[11:0]}. A link with no hits produces no words.
- R7: A trigger of length L (0 counts as 1) takes L end-of-event markers from every link. All hits read before the L-th marker are sent as one group for that link, and words after that marker stay queued for the next event.
- R8: When a link's queue stays empty for TMO consecutive cycles while the builder waits on it, the builder moves on to the next link and sends the hits it has already read.
- R9: Each receive queue holds 128 words. A word pushed into a full queue is dropped and sets that link's overflow flag. The flag is reported in the mask word of the next event to complete and is then cleared.
- R10: Up to 16 triggers can be pending. `trig_ready` is low while 16 are pending, and a trigger offered then is ignored. Events are sent in the order their triggers were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lnk_push | input | 16 | Per-link word strobe |
| lnk_eoe | input | 16 | Per-link flag: the strobed word is an end-of-event marker |
| lnk_hit | input | 192 | Per-link 12-bit hit words, link i at bits [12i+11:12i] |
| trig_valid | input | 1 | Pending trigger offered |
| trig_id | input | 8 | Trigger ID |
| trig_len | input | 4 | Number of contiguous crossings merged into the event |
| trig_ready | output | 1 | Trigger queue can accept a trigger |
| dual_en | input | 1 | Split the output over both lines |
| rate_sel | input | 2 | Bit period select |
| dout0 | output | 1 | Serial output, first line |
| dout1 | output | 1 | Serial output, second line |

## Verification
The serial lines change only at a clock edge where the bit-period divider wraps. The bench therefore finds a frame on the first falling edge at which `dout0` reads 1, and then samples both lines every 4, 2 or 1 falling edges, depending on `rate_sel`, until 18 or 9 periods have been read. It rebuilds each word from those samples and compares it with the next word that its behavioural model predicted from the link queues and the trigger, so a check does not depend on when the builder happens to produce the word. `dout1` is compared on every clock while `dual_en` is low. `trig_ready` is read one falling edge after the sixteenth trigger, which lands in the cycle after the queue fills.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int WORD_W = 16;
  localparam int HIT_W  = 12;

  localparam logic [3:0] TAG_HDR = 4'hE;
  localparam logic [3:0] TAG_LNK = 4'hD;
  localparam logic [3:0] TAG_HIT = 4'h0;
  localparam logic [3:0] TAG_TRL = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DRAIN,
    ST_NEXT,
    ST_TRL,
    ST_MASK
  } bld_state_e;
endpackage

// File: rtl/evb_fifo.sv
module evb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_q];

  always_comb begin
    wr_d  = do_push ? wr_q + 1'b1 : wr_q;
    rd_d  = do_pop  ? rd_q + 1'b1 : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R10
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full); // R9
endmodule

// File: rtl/evb_ser.sv
module evb_ser #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual,
  input  logic [1:0]        rate_sel,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              dout0,
  output logic              dout1
);
  localparam int FR_W = WORD_W + 2;
  localparam int PW   = $clog2(FR_W + 1);

  logic [1:0]      div_q, div_d, per_m1;
  logic            tick;
  logic            busy_q, busy_d;
  logic [FR_W-1:0] sh_q, sh_d;
  logic [PW-1:0]   left_q, left_d;
  logic            d0_q, d0_d, d1_q, d1_d;
  logic            last;

  always_comb begin
    case (rate_sel)
      2'd0:    per_m1 = 2'd3;
      2'd1:    per_m1 = 2'd1;
      default: per_m1 = 2'd0;
    endcase
  end

  assign tick     = (div_q >= per_m1);
  assign div_d    = tick ? 2'd0 : div_q + 2'd1;
  assign last     = (left_q == PW'(1));
  assign in_ready = tick && (!busy_q || last);
  assign dout0    = d0_q;
  assign dout1    = d1_q;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    left_d = left_q;
    d0_d   = d0_q;
    d1_d   = d1_q;
    if (tick) begin
      if (in_valid && (!busy_q || last)) begin
        sh_d   = {1'b1, in_word, 1'b0};
        left_d = dual ? PW'(FR_W / 2) : PW'(FR_W);
        busy_d = 1'b1;
      end else if (busy_q && !last) begin
        sh_d   = dual ? (sh_q << 2) : (sh_q << 1);
        left_d = left_q - 1'b1;
      end else begin
        busy_d = 1'b0;
      end
      d0_d = busy_d && sh_d[FR_W-1];
      d1_d = busy_d && dual && sh_d[FR_W-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      busy_q <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
      d0_q   <= 1'b0;
      d1_q   <= 1'b0;
    end else begin
      div_q  <= div_d;
      busy_q <= busy_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      d0_q   <= d0_d;
      d1_q   <= d1_d;
    end
  end

  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(dout0) && $stable(dout1))); // R4
  AST_SINGLE_LINE1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dual) |=> !dout1); // R2
endmodule

// File: rtl/evb_top.sv
module evb_top
  import evb_pkg::*;
#(
  parameter int NLINK  = 16,
  parameter int QDEPTH = 128,
  parameter int PDEP   = 16,
  parameter int TMO    = 64,
  parameter int ID_W   = 8,
  parameter int LEN_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NLINK-1:0]       lnk_push,
  input  logic [NLINK-1:0]       lnk_eoe,
  input  logic [NLINK*HIT_W-1:0] lnk_hit,
  input  logic                   trig_valid,
  input  logic [ID_W-1:0]        trig_id,
  input  logic [LEN_W-1:0]       trig_len,
  output logic                   trig_ready,
  input  logic                   dual_en,
  input  logic [1:0]             rate_sel,
  output logic                   dout0,
  output logic                   dout1
);
  localparam int LW   = $clog2(NLINK);
  localparam int QE_W = HIT_W + 1;
  localparam int TW   = $clog2(TMO + 1);
  localparam int TF_W = LEN_W + ID_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // per-link receive queues
  logic [QE_W-1:0]  q_head [NLINK];
  logic [NLINK-1:0] q_empty, q_full, q_ovf, q_pop;
  logic             pop_cur;

  for (genvar i = 0; i < NLINK; i++) begin : g_rx
    assign q_ovf[i] = lnk_push[i] && q_full[i];
    assign q_pop[i] = pop_cur && (LW'(i) == li_q);
    evb_fifo #(.W(QE_W), .DEPTH(QDEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_i_n),
      .push  (lnk_push[i]),
      .wdata ({lnk_eoe[i], lnk_hit[i*HIT_W +: HIT_W]}),
      .pop   (q_pop[i]),
      .rdata (q_head[i]),
      .empty (q_empty[i]),
      .full  (q_full[i])
    );
  end

  // pending triggers
  logic [TF_W-1:0] tf_head;
  logic            tf_empty, tf_full, tf_pop;
  evb_fifo #(.W(TF_W), .DEPTH(PDEP)) u_trig (
    .clk   (clk),
    .rst_n (rst_i_n),
    .push  (trig_valid),
    .wdata ({trig_len, trig_id}),
    .pop   (tf_pop),
    .rdata (tf_head),
    .empty (tf_empty),
    .full  (tf_full)
  );
  assign trig_ready = !tf_full;

  logic [ID_W-1:0]  cur_id;
  logic [LEN_W-1:0] cur_len, eff_len;
  assign {cur_len, cur_id} = tf_head;
  assign eff_len = (cur_len == '0) ? LEN_W'(1) : cur_len;

  // builder
  bld_state_e       st_q, st_d;
  logic [LW-1:0]    li_q, li_d;
  logic [LEN_W-1:0] eoe_q, eoe_d;
  logic             lhdr_q, lhdr_d;
  logic [TW-1:0]    tmo_q, tmo_d;
  logic [NLINK-1:0] err_q, err_d;
  logic             err_clr;
  logic             out_valid, out_ready;
  logic [WORD_W-1:0] out_word;
  logic [QE_W-1:0]  head;

  assign head = q_head[li_q];

  always_comb begin
    st_d      = st_q;
    li_d      = li_q;
    eoe_d     = eoe_q;
    lhdr_d    = lhdr_q;
    tmo_d     = tmo_q;
    out_valid = 1'b0;
    out_word  = '0;
    pop_cur   = 1'b0;
    tf_pop    = 1'b0;
    err_clr   = 1'b0;
    case (st_q)
      ST_IDLE: if (!tf_empty) st_d = ST_HDR;
      ST_HDR: begin
        out_valid = 1'b1;
        out_word  = {TAG_HDR, cur_len, cur_id};
        if (out_ready) begin
          st_d   = ST_DRAIN;
          li_d   = '0;
          eoe_d  = '0;
          lhdr_d = 1'b0;
          tmo_d  = '0;
        end
      end
      ST_DRAIN: begin
        if (!q_empty[li_q]) begin
          tmo_d = '0;
          if (head[HIT_W]) begin
            pop_cur = 1'b1;
            if (eoe_q + 1'b1 == eff_len) st_d = ST_NEXT;
            else                          eoe_d = eoe_q + 1'b1;
          end else if (!lhdr_q) begin
            out_valid = 1'b1;
            out_word  = {TAG_LNK, {(WORD_W-4-LW){1'b0}}, li_q};
            if (out_ready) lhdr_d = 1'b1;
          end else begin
            out_valid = 1'b1;
            out_word  = {TAG_HIT, head[HIT_W-1:0]};
            pop_cur   = out_ready;
          end
        end else if (tmo_q == TW'(TMO - 1)) begin
          st_d = ST_NEXT;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      ST_NEXT: begin
        if (li_q == LW'(NLINK - 1)) begin
          st_d = ST_TRL;
        end else begin
          li_d   = li_q + 1'b1;
          eoe_d  = '0;
          lhdr_d = 1'b0;
          tmo_d  = '0;
          st_d   = ST_DRAIN;
        end
      end
      ST_TRL: begin
        out_valid = 1'b1;
        out_word  = {TAG_TRL, {(WORD_W-4){1'b0}}};
        if (out_ready) st_d = ST_MASK;
      end
      ST_MASK: begin
        out_valid = 1'b1;
        out_word  = err_q;
        if (out_ready) begin
          err_clr = 1'b1;
          tf_pop  = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    err_d = (err_clr ? '0 : err_q) | q_ovf;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      li_q   <= '0;
      eoe_q  <= '0;
      lhdr_q <= 1'b0;
      tmo_q  <= '0;
      err_q  <= '0;
    end else begin
      st_q   <= st_d;
      li_q   <= li_d;
      eoe_q  <= eoe_d;
      lhdr_q <= lhdr_d;
      tmo_q  <= tmo_d;
      err_q  <= err_d;
    end
  end

  evb_ser #(.WORD_W(WORD_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .dual     (dual_en),
    .rate_sel (rate_sel),
    .in_valid (out_valid),
    .in_word  (out_word),
    .in_ready (out_ready),
    .dout0    (dout0),
    .dout1    (dout1)
  );

  AST_LINK_STEP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (li_q != $past(li_q)) |-> ((li_q == $past(li_q) + 1'b1) || (li_q == '0))); // R6
  AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|q_ovf) |=> ((err_q & $past(q_ovf)) == $past(q_ovf))); // R9
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_DRAIN) |-> (tmo_q < TW'(TMO))); // R8
endmodule

// File: tb/tb_evb_top.sv
module tb_evb_top;
  localparam int NL  = 16;
  localparam int QD  = 128;
  localparam int TMO = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   lnk_push = '0;
  logic [NL-1:0]   lnk_eoe = '0;
  logic [NL*12-1:0] lnk_hit = '0;
  logic            trig_valid = 1'b0;
  logic [7:0]      trig_id = '0;
  logic [3:0]      trig_len = '0;
  logic            trig_ready;
  logic            dual_en = 1'b0;
  logic [1:0]      rate_sel = 2'd2;
  logic            dout0, dout1;

  always #10 clk = ~clk;

  evb_top #(.NLINK(NL), .QDEPTH(QD), .PDEP(16), .TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .lnk_push(lnk_push), .lnk_eoe(lnk_eoe),
    .lnk_hit(lnk_hit), .trig_valid(trig_valid), .trig_id(trig_id),
    .trig_len(trig_len), .trig_ready(trig_ready), .dual_en(dual_en),
    .rate_sel(rate_sel), .dout0(dout0), .dout1(dout1)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural model
  int          lq [NL][$];
  logic [15:0] exp_w [$];
  string       exp_r [$];
  logic [15:0] err_m = '0;
  string       cur_req = "R5";

  task automatic check(string r, int got, int want, string what);
    n_cmp++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: %s got %h expected %h", r, what, got, want);
    end
  endtask

  task automatic push(int l, bit e, int h);
    @(negedge clk);
    lnk_push = '0; lnk_push[l] = 1'b1;
    lnk_eoe  = '0; lnk_eoe[l]  = e;
    lnk_hit[l*12 +: 12] = 12'(h);
    if (lq[l].size() >= QD) err_m[l] = 1'b1;
    else lq[l].push_back(e ? 32'h1000 : (h & 32'hFFF));
    @(negedge clk);
    lnk_push = '0;
    lnk_eoe  = '0;
  endtask

  task automatic eoe_all();
    for (int l = 0; l < NL; l++) push(l, 1'b1, 0);
  endtask

  task automatic expect_w(logic [15:0] w, string r);
    exp_w.push_back(w);
    exp_r.push_back(r);
  endtask

  task automatic build_event(int id, int len);
    int eff;
    eff = (len == 0) ? 1 : len;
    expect_w({4'hE, 4'(len), 8'(id)}, "R5");
    for (int l = 0; l < NL; l++) begin
      int hits [$];
      int cnt;
      cnt = 0;
      while (lq[l].size() > 0 && cnt < eff) begin
        int v;
        v = lq[l].pop_front();
        if (v[12]) cnt++;
        else hits.push_back(v);
      end
      if (hits.size() > 0) begin
        expect_w({4'hD, 8'h00, 4'(l)}, "R6");
        foreach (hits[k]) expect_w({4'h0, 12'(hits[k])}, cur_req);
      end
    end
    expect_w(16'hF000, "R5");
    expect_w(err_m, "R9");
    err_m = '0;
  endtask

  task automatic trig(int id, int len);
    @(negedge clk);
    trig_valid = 1'b1;
    trig_id    = 8'(id);
    trig_len   = 4'(len);
    if (trig_ready) build_event(id, len);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  // frame decoder
  bit in_fr = 0;
  int fc = 0;
  int nper = 0;
  bit s0 [18];
  bit s1 [18];

  function automatic int per_len();
    return (rate_sel == 2'd0) ? 4 : (rate_sel == 2'd1) ? 2 : 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!dual_en) check("R2", int'(dout1), 0, "dout1 in single mode");
      if (!in_fr && dout0) begin
        in_fr = 1; fc = 0; nper = 0;
      end
      if (in_fr) begin
        int p, np;
        p  = per_len();
        np = dual_en ? 9 : 18;
        if (fc % p == 0) begin
          s0[nper] = dout0; s1[nper] = dout1; nper++;
        end
        if (fc == np * p - 1) begin
          logic [17:0] st;
          st = '0;
          for (int k = 0; k < np; k++) begin
            if (dual_en) begin
              st[17-2*k] = s0[k];
              st[16-2*k] = s1[k];
            end else begin
              st[17-k] = s0[k];
            end
          end
          check(dual_en ? "R3" : "R2", int'(st[0]), 0, "stop bit");
          if (exp_w.size() == 0) begin
            check("R5", int'(st[16:1]), -1, "unexpected word");
          end else begin
            logic [15:0] e;
            string r;
            e = exp_w.pop_front();
            r = exp_r.pop_front();
            check(r, int'(st[16:1]), int'(e), "word");
          end
          in_fr = 0;
        end else begin
          fc++;
        end
      end
    end
  end

  task automatic drain();
    while (exp_w.size() != 0 || in_fr) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10: watchdog expired got %0d words pending expected 0", exp_w.size());
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", int'(dout0), 0, "dout0 in reset");
    check("R1", int'(dout1), 0, "dout1 in reset");
    check("R1", int'(trig_ready), 1, "trig_ready in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: link order, empty links silent, single line, fastest rate
    cur_req = "R6";
    push(7, 0, 12'h777); push(0, 0, 12'h001); push(2, 0, 12'h0A2);
    push(0, 0, 12'h002);
    eoe_all();
    trig(8'h11, 1);
    drain();

    // R4: slower rates, single line
    cur_req = "R4";
    rate_sel = 2'd0;
    push(4, 0, 12'hC4D); eoe_all();
    trig(8'h22, 1);
    drain();
    rate_sel = 2'd1;
    push(15, 0, 12'hFFE); push(9, 0, 12'h5A5); eoe_all();
    trig(8'h23, 1);
    drain();

    // R3: two-line output at two rates
    cur_req = "R3";
    dual_en = 1'b1;
    rate_sel = 2'd2;
    push(1, 0, 12'hABC); push(3, 0, 12'h123); eoe_all();
    trig(8'h33, 1);
    drain();
    rate_sel = 2'd0;
    push(6, 0, 12'h9F0); eoe_all();
    trig(8'h34, 1);
    drain();
    dual_en = 1'b0;
    rate_sel = 2'd2;

    // R7: two crossings merged, a third stays queued
    cur_req = "R7";
    push(5, 0, 12'h051); eoe_all();
    push(5, 0, 12'h052); push(8, 0, 12'h081); eoe_all();
    push(5, 0, 12'h053); eoe_all();
    trig(8'h44, 2);
    drain();
    trig(8'h45, 0);
    drain();

    // R8: link 3 never closes its event
    cur_req = "R8";
    push(3, 0, 12'h333); push(3, 0, 12'h334);
    for (int l = 0; l < NL; l++) if (l != 3) push(l, 1'b1, 0);
    trig(8'h55, 1);
    drain();

    // R9: overflow on link 5, flag reported once
    cur_req = "R9";
    for (int k = 0; k < QD - 1; k++) push(5, 0, k + 1);
    push(5, 1'b1, 0);
    push(5, 0, 12'hBAD); push(5, 0, 12'hBAD);
    for (int l = 0; l < NL; l++) if (l != 5) push(l, 1'b1, 0);
    trig(8'h66, 1);
    drain();
    eoe_all();
    trig(8'h67, 1);
    drain();

    // R10: sixteen pending triggers, seventeenth refused, order kept
    cur_req = "R10";
    for (int k = 0; k < 16; k++) trig(8'h80 + k, 1);
    check("R10", int'(trig_ready), 0, "trig_ready with 16 pending");
    trig(8'hEE, 1);
    drain();
    check("R10", int'(trig_ready), 1, "trig_ready after drain");

    summary();
  end
endmodule